// File: doc/BRIEF.md
# ISA-Style I/O Bus Slave Front End with Single-Channel DMA Handshake

This block sits between an 8-bit ISA-style host I/O bus and the register file of a peripheral. It turns host read and write commands into one-cycle register strobes on the system clock. It latches the 11-bit I/O address at the start of each command. It decides when the chip may drive the shared data bus, and it holds the host off through an open-drain ready line while the internal function is busy. All host command lines pass through two-flop synchronizers. Command starts are found from falling edges of the synchronized lines, so the first strobe appears on the third system clock edge after a command line falls.

The block also runs one DMA channel. The internal function raises a request and later marks the byte that ends the transfer. The block drives DRQ to the host and clears it in one of two ways. In single transfers it clears on the acknowledge falling. In demand transfers, where the acknowledge is already low, it clears on the read command falling. While the acknowledge is low, host reads and writes reach the register path without any address decode. The terminal-count input is looked at only on those acknowledged bytes, and its active level is chosen by a mode input.

The command sequencer has four states. CMD_IDLE goes to CMD_READ on an accepted read, or to CMD_WR_WAIT on an accepted write. CMD_READ returns to CMD_IDLE when the read line rises. CMD_WR_WAIT goes to CMD_WR_DONE when the function is ready, issuing the write strobe, or back to CMD_IDLE if the write line rises first. CMD_WR_DONE returns to CMD_IDLE when the write line rises. The request sequencer has three states. DRQ_OFF goes to DRQ_ON when a request is seen. DRQ_ON goes to DRQ_ARMED when the last-byte mark is seen. DRQ_ARMED goes back to DRQ_OFF on the clearing event.

Top module: `isa_bus_slave`

## Requirements
- R1: While rst is high and right after it falls, drq, bus_oe, iochrdy_low, fn_rd, fn_wr and fn_tc_done are all 0.
- R2: A read with dack_n high is accepted only when cs_n is low, aen is low and addr[10:3] equals the base 0x3F8 >> 3 (window 0x3F8 to 0x3FF). Any other value of bits 10 to 3 is ignored. An accepted read gives exactly one fn_rd pulse and presents the address sampled at the start of the command on fn_addr.
- R3: While cs_n is high, no read or write is accepted unless dack_n is low.
- R4: While aen is high, no read or write is accepted unless dack_n is low.
- R5: bus_oe is 1 only from an accepted read until its read line has risen. bus_rd_data equals fn_rdata while bus_oe is 1, and 0 otherwise.
- R6: While dack_n is low, any read or write is accepted whatever addr, cs_n and aen are. Its strobe has fn_dma set to 1, and fn_addr keeps its previous value.
- R7: An accepted write produces one fn_wr pulse in the first cycle fn_ready is high. fn_wdata holds the bus_wr_data sampled then. If the write line rises before fn_ready, no fn_wr is produced.
- R8: iochrdy_low is 1 exactly while an accepted read is open, or an accepted write waits for its strobe, and fn_ready is 0.
- R9: drq rises one edge after fn_dma_req is seen high. It stays high through acknowledges and reads until fn_last_byte has been seen.
- R10: Once armed by fn_last_byte, drq clears on a falling edge of dack_n.
- R11: Once armed, if dack_n is already low, drq clears on a falling edge of ior_n.
- R12: fn_tc_done pulses for one cycle when a read or write is accepted with dack_n low and tc is active. tc is active high when ps2_mode is 0 and active low when ps2_mode is 1. Cycles with dack_n high never pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset of the bus interface state |
| cs_n | input | 1 | Active-low chip select from the external upper-address decoder |
| aen | input | 1 | Address enable; high marks a DMA cycle on the bus |
| ior_n | input | 1 | Active-low host I/O read command |
| iow_n | input | 1 | Active-low host I/O write command |
| addr | input | 11 | Host I/O address |
| bus_wr_data | input | 8 | Data the host drives on the bus |
| bus_rd_data | output | 8 | Data the chip drives on the bus when enabled |
| bus_oe | output | 1 | Enable for the tri-state data bus driver |
| iochrdy_low | output | 1 | 1 pulls the open-drain ready line low |
| dack_n | input | 1 | Active-low DMA acknowledge |
| tc | input | 1 | Terminal count |
| ps2_mode | input | 1 | 0 selects active-high terminal count, 1 selects active-low |
| drq | output | 1 | DMA request to the host |
| fn_ready | input | 1 | Internal function can complete the current access |
| fn_rdata | input | 8 | Read data from the internal function |
| fn_dma_req | input | 1 | Internal function wants a DMA transfer |
| fn_last_byte | input | 1 | Internal function marks the transfer's final byte |
| fn_rd | output | 1 | One-cycle register read strobe |
| fn_wr | output | 1 | One-cycle register write strobe |
| fn_dma | output | 1 | The current or last strobe belongs to a DMA byte |
| fn_addr | output | 11 | Latched I/O address |
| fn_wdata | output | 8 | Latched write data |
| fn_tc_done | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench aims at the decode window edges: a miss in bit 8, a miss in bit 10, chip select high and address enable high. A decoder that compared too few bits, or ignored either qualifier, would raise a read strobe there. It then makes both DRQ clearing orders happen. In one, the acknowledge falls after the last-byte mark. In the other, the acknowledge is already low and only the read edge can clear. A design with a single clearing rule would leave the request stuck high, or drop it on an ordinary acknowledged byte. Terminal count is driven at both levels under both modes, and also with the acknowledge high. An inverted or ungated polarity would then show up as a missing or extra pulse. A write that ends before the function is ready checks that no strobe leaks out.

// File: rtl/isa_pkg.sv
package isa_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_READ,
        CMD_WR_WAIT,
        CMD_WR_DONE
    } cmd_state_t;

    typedef enum logic [1:0] {
        DRQ_OFF,
        DRQ_ON,
        DRQ_ARMED
    } drq_state_t;

endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
    parameter int                 WIDTH   = 5,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or posedge rst) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge rst) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/isa_cmd_fsm.sv
module isa_cmd_fsm
    import isa_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ior_fall,
    input  logic              iow_fall,
    input  logic              ior_s,
    input  logic              iow_s,
    input  logic              dack_s,
    input  logic              io_hit,
    input  logic              tc_active,
    input  logic              fn_ready,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              rd_busy,
    output logic              wr_wait,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic              dma_flag,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              tc_pulse
);

    cmd_state_t state_q, state_d;
    logic dma_now;
    logic rd_take;
    logic wr_take;
    logic wr_fire;

    assign dma_now = ~dack_s;
    assign rd_take = ior_fall & (dma_now | io_hit);
    assign wr_take = ~rd_take & iow_fall & (dma_now | io_hit);
    assign wr_fire = (state_q == CMD_WR_WAIT) & ~iow_s & fn_ready;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= CMD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (rd_take)      state_d = CMD_READ;
                else if (wr_take) state_d = CMD_WR_WAIT;
            end
            CMD_READ: begin
                if (ior_s) state_d = CMD_IDLE;
            end
            CMD_WR_WAIT: begin
                if (iow_s)         state_d = CMD_IDLE;
                else if (fn_ready) state_d = CMD_WR_DONE;
            end
            CMD_WR_DONE: begin
                if (iow_s) state_d = CMD_IDLE;
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rd_pulse <= 1'b0;
            wr_pulse <= 1'b0;
            tc_pulse <= 1'b0;
            dma_flag <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            rd_pulse <= (state_q == CMD_IDLE) & rd_take;
            wr_pulse <= wr_fire;
            tc_pulse <= (state_q == CMD_IDLE) & (rd_take | wr_take) & dma_now & tc_active;
            if ((state_q == CMD_IDLE) && (rd_take || wr_take)) begin
                dma_flag <= dma_now;
                if (!dma_now) addr_q <= addr_in;
            end
            if (wr_fire) wdata_q <= data_in;
        end
    end

    assign rd_busy = (state_q == CMD_READ);
    assign wr_wait = (state_q == CMD_WR_WAIT);

endmodule

// File: rtl/isa_drq_fsm.sv
module isa_drq_fsm
    import isa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dma_req,
    input  logic last_byte,
    input  logic dack_s,
    input  logic dack_fall,
    input  logic ior_fall,
    output logic drq
);

    drq_state_t state_q, state_d;
    logic clear_evt;

    assign clear_evt = dack_fall | (ior_fall & ~dack_s);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= DRQ_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRQ_OFF: begin
                if (dma_req) state_d = DRQ_ON;
            end
            DRQ_ON: begin
                if (last_byte) state_d = DRQ_ARMED;
            end
            DRQ_ARMED: begin
                if (clear_evt) state_d = DRQ_OFF;
            end
            default: state_d = DRQ_OFF;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) drq <= 1'b0;
        else     drq <= (state_d != DRQ_OFF);
    end

endmodule

// File: rtl/isa_bus_slave.sv
module isa_bus_slave #(
    parameter int                ADDR_W      = 11,
    parameter int                DATA_W      = 8,
    parameter int                WIN_BITS    = 3,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 11'h3F8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              aen,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_wr_data,
    output logic [DATA_W-1:0] bus_rd_data,
    output logic              bus_oe,
    output logic              iochrdy_low,
    input  logic              dack_n,
    input  logic              tc,
    input  logic              ps2_mode,
    output logic              drq,
    input  logic              fn_ready,
    input  logic [DATA_W-1:0] fn_rdata,
    input  logic              fn_dma_req,
    input  logic              fn_last_byte,
    output logic              fn_rd,
    output logic              fn_wr,
    output logic              fn_dma,
    output logic [ADDR_W-1:0] fn_addr,
    output logic [DATA_W-1:0] fn_wdata,
    output logic              fn_tc_done
);

    localparam int TAG_W = ADDR_W - WIN_BITS;
    localparam int NSYNC = 5;
    localparam logic [NSYNC-1:0] SYNC_IDLE = 5'b00111;

    logic [NSYNC-1:0] raw_v, sync_v;
    logic ior_s, iow_s, dack_s, aen_s, tc_s;
    logic ior_p, iow_p, dack_p;
    logic ior_fall, iow_fall, dack_fall;
    logic io_hit, tc_active;
    logic rd_busy, wr_wait;

    assign raw_v = {tc, aen, dack_n, iow_n, ior_n};

    isa_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_v),
        .q  (sync_v)
    );

    assign ior_s  = sync_v[0];
    assign iow_s  = sync_v[1];
    assign dack_s = sync_v[2];
    assign aen_s  = sync_v[3];
    assign tc_s   = sync_v[4];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ior_p  <= 1'b1;
            iow_p  <= 1'b1;
            dack_p <= 1'b1;
        end else begin
            ior_p  <= ior_s;
            iow_p  <= iow_s;
            dack_p <= dack_s;
        end
    end

    assign ior_fall  = ior_p  & ~ior_s;
    assign iow_fall  = iow_p  & ~iow_s;
    assign dack_fall = dack_p & ~dack_s;

    assign io_hit = ~cs_n & ~aen_s & dack_s
                  & (addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
    assign tc_active = ps2_mode ? ~tc_s : tc_s;

    isa_cmd_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .ior_fall (ior_fall),
        .iow_fall (iow_fall),
        .ior_s    (ior_s),
        .iow_s    (iow_s),
        .dack_s   (dack_s),
        .io_hit   (io_hit),
        .tc_active(tc_active),
        .fn_ready (fn_ready),
        .addr_in  (addr),
        .data_in  (bus_wr_data),
        .rd_busy  (rd_busy),
        .wr_wait  (wr_wait),
        .rd_pulse (fn_rd),
        .wr_pulse (fn_wr),
        .dma_flag (fn_dma),
        .addr_q   (fn_addr),
        .wdata_q  (fn_wdata),
        .tc_pulse (fn_tc_done)
    );

    isa_drq_fsm u_drq (
        .clk      (clk),
        .rst      (rst),
        .dma_req  (fn_dma_req),
        .last_byte(fn_last_byte),
        .dack_s   (dack_s),
        .dack_fall(dack_fall),
        .ior_fall (ior_fall),
        .drq      (drq)
    );

    assign bus_oe      = rd_busy;
    assign bus_rd_data = rd_busy ? fn_rdata : '0;
    assign iochrdy_low = (rd_busy | wr_wait) & ~fn_ready;

endmodule

// File: rtl/isa_bus_slave_chk.sv
module isa_bus_slave_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic dack_n,
    input logic fn_dma_req,
    input logic fn_ready,
    input logic drq,
    input logic fn_rd,
    input logic fn_wr,
    input logic fn_dma,
    input logic bus_oe,
    input logic iochrdy_low,
    input logic fn_tc_done
);

    a_r2_rd_single: assert property (@(posedge clk) disable iff (rst)
        fn_rd |=> !fn_rd);

    a_r3_cs_gates_decode: assert property (@(posedge clk) disable iff (rst)
        (fn_rd && !fn_dma) |-> $past(!cs_n));

    a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !fn_wr);

    a_r7_wr_single: assert property (@(posedge clk) disable iff (rst)
        fn_wr |=> !fn_wr);

    a_r8_hold_only_unready: assert property (@(posedge clk) disable iff (rst)
        iochrdy_low |-> !fn_ready);

    a_r9_drq_from_req: assert property (@(posedge clk) disable iff (rst)
        $rose(drq) |-> $past(fn_dma_req));

    a_r12_tc_single: assert property (@(posedge clk) disable iff (rst)
        fn_tc_done |=> !fn_tc_done);

    a_r12_tc_needs_dack: assert property (@(posedge clk) disable iff (rst)
        fn_tc_done |-> !$past(dack_n, 3));

endmodule

bind isa_bus_slave isa_bus_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .dack_n     (dack_n),
    .fn_dma_req (fn_dma_req),
    .fn_ready   (fn_ready),
    .drq        (drq),
    .fn_rd      (fn_rd),
    .fn_wr      (fn_wr),
    .fn_dma     (fn_dma),
    .bus_oe     (bus_oe),
    .iochrdy_low(iochrdy_low),
    .fn_tc_done (fn_tc_done)
);

// File: tb/isa_bus_slave_test.sv
module isa_bus_slave_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, cs_n, aen, ior_n, iow_n, dack_n, tc, ps2_mode;
    logic [10:0] addr;
    logic [7:0]  bus_wr_data, bus_rd_data, fn_rdata, fn_wdata;
    logic        bus_oe, iochrdy_low, drq, fn_ready, fn_dma_req, fn_last_byte;
    logic        fn_rd, fn_wr, fn_dma, fn_tc_done;
    logic [10:0] fn_addr;

    isa_bus_slave uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
        .addr(addr), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
        .bus_oe(bus_oe), .iochrdy_low(iochrdy_low), .dack_n(dack_n), .tc(tc),
        .ps2_mode(ps2_mode), .drq(drq), .fn_ready(fn_ready), .fn_rdata(fn_rdata),
        .fn_dma_req(fn_dma_req), .fn_last_byte(fn_last_byte), .fn_rd(fn_rd),
        .fn_wr(fn_wr), .fn_dma(fn_dma), .fn_addr(fn_addr), .fn_wdata(fn_wdata),
        .fn_tc_done(fn_tc_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int cnt_rd, cnt_wr, cnt_tc, cnt_oe, cnt_rdy, cnt_dma;

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit q_ior[$], q_iow[$], q_dack[$], q_aen[$], q_tc[$];
    int       m_cmd;   // 0 idle, 1 read open, 2 write waiting, 3 write done
    int       m_req;   // 0 off, 1 on, 2 armed
    bit       m_rd, m_wr, m_tc, m_dma;
    bit [10:0] m_addr;
    bit [7:0]  m_wdata;

    always @(posedge clk) begin
        if (rst) begin
            q_ior = '{1, 1, 1, 1}; q_iow = '{1, 1, 1, 1}; q_dack = '{1, 1, 1, 1};
            q_aen = '{0, 0, 0, 0}; q_tc = '{0, 0, 0, 0};
            m_cmd = 0; m_req = 0; m_rd = 0; m_wr = 0; m_tc = 0; m_dma = 0;
            m_addr = 0; m_wdata = 0;
        end else begin
            bit rs, rp, ws, wp, ds, dp, as_, ts, rf, wf, df, hit, tca, dma;
            q_ior.push_front(ior_n);   void'(q_ior.pop_back());
            q_iow.push_front(iow_n);   void'(q_iow.pop_back());
            q_dack.push_front(dack_n); void'(q_dack.pop_back());
            q_aen.push_front(aen);     void'(q_aen.pop_back());
            q_tc.push_front(tc);       void'(q_tc.pop_back());
            rs = q_ior[2];  rp = q_ior[3];
            ws = q_iow[2];  wp = q_iow[3];
            ds = q_dack[2]; dp = q_dack[3];
            as_ = q_aen[2]; ts = q_tc[2];
            rf = rp && !rs; wf = wp && !ws; df = dp && !ds;
            dma = !ds;
            hit = !cs_n && !as_ && ds && ((addr >> 3) == (11'h3F8 >> 3));
            tca = ps2_mode ? !ts : ts;
            m_rd = 0; m_wr = 0; m_tc = 0;
            case (m_cmd)
                0: if (rf && (dma || hit)) begin
                        m_cmd = 1; m_rd = 1; m_dma = dma; m_tc = dma && tca;
                        if (!dma) m_addr = addr;
                    end else if (wf && (dma || hit)) begin
                        m_cmd = 2; m_dma = dma; m_tc = dma && tca;
                        if (!dma) m_addr = addr;
                    end
                1: if (rs) m_cmd = 0;
                2: if (ws) m_cmd = 0;
                   else if (fn_ready) begin m_cmd = 3; m_wr = 1; m_wdata = bus_wr_data; end
                default: if (ws) m_cmd = 0;
            endcase
            case (m_req)
                0: if (fn_dma_req) m_req = 1;
                1: if (fn_last_byte) m_req = 2;
                default: if (df || (rf && !ds)) m_req = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R9 drq",         drq,        m_req != 0);
            check("R2 fn_rd",       fn_rd,      m_rd);
            check("R7 fn_wr",       fn_wr,      m_wr);
            check("R12 fn_tc_done", fn_tc_done, m_tc);
            check("R2 fn_addr",     fn_addr,    m_addr);
            check("R6 fn_dma",      fn_dma,     m_dma);
            check("R7 fn_wdata",    fn_wdata,   m_wdata);
            check("R5 bus_oe",      bus_oe,     m_cmd == 1);
            check("R5 bus_rd_data", bus_rd_data, (m_cmd == 1) ? fn_rdata : 8'h00);
            check("R8 iochrdy_low", iochrdy_low, (m_cmd == 1 || m_cmd == 2) && !fn_ready);
            if (fn_rd) cnt_rd++;
            if (fn_wr) cnt_wr++;
            if (fn_tc_done) cnt_tc++;
            if (bus_oe) cnt_oe++;
            if (iochrdy_low) cnt_rdy++;
            if ((fn_rd || fn_wr) && fn_dma) cnt_dma++;
        end
    end

    task automatic clr();
        cnt_rd = 0; cnt_wr = 0; cnt_tc = 0; cnt_oe = 0; cnt_rdy = 0; cnt_dma = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_cycle(bit wr, logic [10:0] a, bit cs, bit ae, int hold,
                              int rdy_delay, logic [7:0] d);
        addr = a; cs_n = cs; aen = ae; bus_wr_data = d;
        fn_ready = (rdy_delay == 0);
        if (wr) iow_n = 1'b0; else ior_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i + 1 >= rdy_delay) fn_ready = 1'b1;
        end
        ior_n = 1'b1; iow_n = 1'b1;
        idle(5);
        cs_n = 1'b1; aen = 1'b0; fn_ready = 1'b1;
    endtask

    task automatic pulse_req();
        fn_dma_req = 1'b1; idle(1); fn_dma_req = 1'b0;
    endtask

    task automatic pulse_last();
        fn_last_byte = 1'b1; idle(1); fn_last_byte = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired, R1 to R12 incomplete");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; cs_n = 1; aen = 0; ior_n = 1; iow_n = 1; dack_n = 1; tc = 0;
        ps2_mode = 0; addr = 0; bus_wr_data = 0; fn_ready = 1; fn_rdata = 8'hA5;
        fn_dma_req = 0; fn_last_byte = 0;
        clr();
        idle(3);
        rst = 0;
        #1;
        check("R1 drq",        drq, 0);
        check("R1 bus_oe",     bus_oe, 0);
        check("R1 iochrdy",    iochrdy_low, 0);
        check("R1 fn_rd",      fn_rd, 0);
        check("R1 fn_wr",      fn_wr, 0);
        check("R1 fn_tc_done", fn_tc_done, 0);
        idle(2);

        // R2 / R5: decoded read
        clr(); host_cycle(0, 11'h3F9, 0, 0, 8, 0, 8'h00);
        check("R2 read hit count", cnt_rd, 1);
        check("R5 drive during read", cnt_oe > 0, 1);

        // R8: read stretched by ready line
        clr(); fn_rdata = 8'h5A; host_cycle(0, 11'h3FA, 0, 0, 10, 6, 8'h00);
        check("R8 ready held low", cnt_rdy > 0, 1);

        // R7: write after ready, then aborted write
        clr(); host_cycle(1, 11'h3FF, 0, 0, 10, 4, 8'h3C);
        check("R7 write count", cnt_wr, 1);
        check("R7 write data", fn_wdata, 8'h3C);
        clr(); host_cycle(1, 11'h3FE, 0, 0, 8, 100, 8'h77);
        check("R7 aborted write", cnt_wr, 0);

        // R2: decode misses in bit 8 and bit 10
        clr(); host_cycle(0, 11'h2F8, 0, 0, 8, 0, 8'h00);
        host_cycle(0, 11'h7F8, 0, 0, 8, 0, 8'h00);
        check("R2 miss count", cnt_rd, 0);
        check("R5 no drive on miss", cnt_oe, 0);

        // R3, R4: qualifiers
        clr(); host_cycle(0, 11'h3F9, 1, 0, 8, 0, 8'h00);
        host_cycle(1, 11'h3F9, 1, 0, 8, 0, 8'h11);
        check("R3 cs high blocks", cnt_rd + cnt_wr, 0);
        clr(); host_cycle(0, 11'h3F9, 0, 1, 8, 0, 8'h00);
        check("R4 aen high blocks", cnt_rd, 0);

        // R9, R6, R10: single-transfer DMA
        pulse_req(); idle(2);
        check("R9 drq set", drq, 1);
        dack_n = 0; idle(5);
        check("R9 drq holds unarmed", drq, 1);
        clr(); host_cycle(0, 11'h000, 1, 1, 8, 0, 8'h00);
        check("R6 dma read count", cnt_rd, 1);
        check("R6 dma flag", cnt_dma, 1);
        check("R9 drq after unarmed read", drq, 1);
        dack_n = 1; idle(4);
        pulse_last(); idle(2);
        check("R10 armed still high", drq, 1);
        dack_n = 0; idle(5);
        check("R10 cleared by dack fall", drq, 0);
        dack_n = 1; idle(4);

        // R11: demand mode
        dack_n = 0; idle(5);
        pulse_req(); pulse_last(); idle(3);
        check("R11 armed with dack low", drq, 1);
        clr(); host_cycle(0, 11'h123, 1, 1, 8, 0, 8'h00);
        check("R11 cleared by read fall", drq, 0);
        check("R6 demand read count", cnt_rd, 1);

        // R12: terminal count polarity
        ps2_mode = 0; tc = 1; idle(3);
        clr(); host_cycle(1, 11'h055, 1, 1, 8, 0, 8'h99);
        check("R12 tc high in mode 0", cnt_tc, 1);
        check("R6 dma write count", cnt_wr, 1);
        ps2_mode = 1; tc = 0; idle(3);
        clr(); host_cycle(0, 11'h055, 1, 1, 8, 0, 8'h00);
        check("R12 tc low in mode 1", cnt_tc, 1);
        tc = 1; idle(3);
        clr(); host_cycle(0, 11'h055, 1, 1, 8, 0, 8'h00);
        check("R12 tc high inactive in mode 1", cnt_tc, 0);
        dack_n = 1; ps2_mode = 0; tc = 1; idle(4);
        clr(); host_cycle(0, 11'h3F8, 0, 0, 8, 0, 8'h00);
        check("R12 tc ignored without dack", cnt_tc, 0);
        check("R2 read at window base", cnt_rd, 1);
        check("R2 address latched", fn_addr, 11'h3F8);

        idle(3);
        done = 1;
        summary();
        $finish;
    end

endmodule